// File: doc/BRIEF.md
# Return From Interrupt Unstacker

This block carries out the stack half of a return from an interrupt handler. When the core pulses a start strobe, the block reads the saved status byte from a byte-wide stack memory, then the two bytes of the resume address, low byte first. In native mode it then reads the saved program bank byte. It hands the restored status, resume address, bank and final stack pointer back to the core together with a one-cycle completion pulse.

The stack pointer is incremented before each byte is read. In emulation mode the stack is confined to one fixed page, so only the low byte of the pointer moves and it wraps inside that page. In native mode the whole 16-bit pointer moves. The restored address is handed back exactly as it was read. A subroutine return adds one to its pulled address, but this block does not. The block assumes a memory whose read data is valid in the same cycle as the address and strobe.

Top module: `rti_unstacker`

## Requirements
- R1: After a synchronous active-low reset, `done` and `rd_en` are 0 and `pc_out`, `bank_out`, `flags_out` and `sp_out` are all zero.
- R2: In emulation mode (`native_mode`=0 when start is taken), the operation spans 6 cycles. `done` is high in the 5th cycle after the cycle in which `start` was sampled high.
- R3: In native mode (`native_mode`=1 when start is taken), the operation spans 7 cycles. `done` is high in the 6th cycle after the start cycle.
- R4: Reads happen in a fixed order and nowhere else. The cycle right after start has no read. Reads then occur in cycles 2, 3 and 4 after start: status at pointer+1, address low byte at pointer+2 and address high byte at pointer+3. In native mode a fourth read of the bank byte follows in cycle 5, at pointer+4. `rd_en` is high in exactly those cycles.
- R5: In emulation mode every read address is {8'h01, sp_in[7:0]+k} with k=1..3. The addition wraps within the page, and sp_in[15:8] has no effect.
- R6: In native mode every read address is sp_in+k with k=1..4, computed modulo 2^16.
- R7: `pc_out` equals {high byte read, low byte read}, with no increment applied.
- R8: In emulation mode, bits 5 and 4 of `flags_out` read 1 whatever the pulled status byte holds, the other bits copy the pulled byte, and `bank_out` is 0.
- R9: In native mode `flags_out` is the pulled status byte unchanged and `bank_out` is the pulled bank byte.
- R10: `sp_out` is the address of the last byte read: {8'h01, sp_in[7:0]+3} in emulation mode, or sp_in+4 in native mode.
- R11: `done` is a single-cycle pulse. The restored outputs are valid in that cycle. A `start` that arrives while an operation is in progress is ignored: it changes neither the addresses, the mode nor the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a return operation (taken only when idle) |
| native_mode | input | 1 | 1 = native mode with bank pull, 0 = emulation mode |
| sp_in | input | 16 | Stack pointer at the start of the operation |
| rd_data | input | 8 | Stack memory read data, valid in the cycle of the address |
| rd_addr | output | 16 | Stack memory read address |
| rd_en | output | 1 | Stack memory read strobe |
| pc_out | output | 16 | Restored resume address |
| bank_out | output | 8 | Restored program bank |
| flags_out | output | 8 | Restored status flags |
| sp_out | output | 16 | Stack pointer after the pulls |
| done | output | 1 | One-cycle pulse: restored values valid |

## Verification
The bench sweeps every low stack-pointer byte in emulation mode, with changing high bytes, so the in-page wrap is hit from every position. A design that carried into the high byte, or that honoured sp_in[15:8], would read the wrong page. In native mode it sweeps pointers just below 16'hFFFF, where a design that wrapped at 8 bits, or that left out the bank read and its extra cycle, would give wrong addresses or an early `done`. Pulled bytes depend on the address, so a design that swapped the address bytes, added one to the resume address or kept bits 5 and 4 from memory in emulation mode would give wrong results. Extra start pulses are injected mid-operation with the pointer and mode flipped, which catches a design that restarts or relatches while busy.

// File: rtl/rti_unstack_pkg.sv
// Package: shared state encoding and status-bit positions for the unstacker.
// Assumes an 8-bit status byte whose bits 5 and 4 carry no flag in emulation mode.
package rti_unstack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_GAP       = 3'd1,
        ST_PULL_P    = 3'd2,
        ST_PULL_LO   = 3'd3,
        ST_PULL_HI   = 3'd4,
        ST_PULL_BANK = 3'd5,
        ST_DONE      = 3'd6
    } rti_state_t;

    localparam int FLAG_BRK_POS  = 4;
    localparam int FLAG_FREE_POS = 5;

endpackage

// File: rtl/rti_seq.sv
// Module: rti_seq
// Cycle sequencer for the return operation. It takes a start only when idle and
// latches the mode. It walks through one gap cycle and then the pull cycles,
// adding the bank pull only in native mode, and signals the end for one cycle.
// Assumes: start is a level sampled each idle cycle.
module rti_seq
    import rti_unstack_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             native_mode,
    output rti_state_t       state,
    output logic             mode_q,
    output logic             accept,
    output logic             rd_en,
    output logic             done,
    output logic [OFF_W-1:0] offset
);

    rti_state_t state_nx;

    assign accept = (state == ST_IDLE) && start;

    // Next-state selection for the pull sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_GAP;
            ST_GAP:       state_nx = ST_PULL_P;
            ST_PULL_P:    state_nx = ST_PULL_LO;
            ST_PULL_LO:   state_nx = ST_PULL_HI;
            ST_PULL_HI:   state_nx = mode_q ? ST_PULL_BANK : ST_DONE;
            ST_PULL_BANK: state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Mode latch, loaded only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= 1'b0;
        else if (accept) mode_q <= native_mode;
    end

    // Read strobe and stack offset decoded from the current pull state.
    always_comb begin
        rd_en  = 1'b1;
        offset = '0;
        unique case (state)
            ST_PULL_P:    offset = OFF_W'(1);
            ST_PULL_LO:   offset = OFF_W'(2);
            ST_PULL_HI:   offset = OFF_W'(3);
            ST_PULL_BANK: offset = OFF_W'(4);
            default:      rd_en  = 1'b0;
        endcase
    end

    assign done = (state == ST_DONE);

    // Read order: status, then low, then high, then bank.
    p_order_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL_LO) |-> ($past(state) == ST_PULL_P));
    p_order_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL_HI) |-> ($past(state) == ST_PULL_LO));
    // Bank pull occurs only for native mode.
    p_bank_native_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL_BANK) |-> mode_q);
    // Completion pulse lasts one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Mode stays fixed while busy, even when start repeats.
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/rti_addr_gen.sv
// Module: rti_addr_gen
// Holds the stack pointer captured at start and forms the read address for
// each pull. Emulation mode keeps the address inside one fixed page by adding
// only to the low byte. Native mode adds to the full pointer.
// Assumes: offset is zero outside the pull cycles.
module rti_addr_gen #(
    parameter int                     SP_W       = 16,
    parameter int                     DATA_W     = 8,
    parameter int                     OFF_W      = 3,
    parameter logic [SP_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [SP_W-1:0]  sp_in,
    input  logic             mode_q,
    input  logic [OFF_W-1:0] offset,
    output logic [SP_W-1:0]  rd_addr
);

    localparam int PAGE_W = SP_W - DATA_W;

    logic [SP_W-1:0]   sp_q;
    logic [DATA_W-1:0] low_sum;
    logic [SP_W-1:0]   full_sum;

    // Pointer capture at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= '0;
        else if (accept) sp_q <= sp_in;
    end

    // Page-wrapped and full-width pre-incremented addresses.
    always_comb begin
        low_sum  = sp_q[DATA_W-1:0] + DATA_W'(offset);
        full_sum = sp_q + SP_W'(offset);
        rd_addr  = mode_q ? full_sum : {STACK_PAGE, low_sum};
    end

    // Pointer stays frozen between starts.
    p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(sp_q));
    // Emulation reads never leave the stack page.
    p_page_emul_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && offset != '0) |-> (rd_addr[SP_W-1:SP_W-PAGE_W] == STACK_PAGE));

endmodule

// File: rtl/rti_capture.sv
// Module: rti_capture
// Loads the restored registers from the read data in each pull cycle. In
// emulation mode it forces the two non-flag status bits to 1 and the bank to
// zero. It also records the address of the last byte read as the final pointer.
// Assumes: rd_data is valid in the same cycle as rd_addr.
module rti_capture
    import rti_unstack_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rti_state_t        state,
    input  logic              mode_q,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [SP_W-1:0]   rd_addr,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] bank_out,
    output logic [DATA_W-1:0] flags_out,
    output logic [SP_W-1:0]   sp_out
);

    localparam logic [DATA_W-1:0] EMU_FORCE =
        DATA_W'((1 << FLAG_BRK_POS) | (1 << FLAG_FREE_POS));

    logic last_pull;

    assign last_pull = (state == ST_PULL_BANK) || ((state == ST_PULL_HI) && !mode_q);

    // Status capture, with the emulation-mode fixed bits applied.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flags_out <= '0;
        else if (state == ST_PULL_P) flags_out <= mode_q ? rd_data : (rd_data | EMU_FORCE);
    end

    // Resume address capture, low byte then high byte, used as read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pc_out <= '0;
        else if (state == ST_PULL_LO) pc_out[DATA_W-1:0] <= rd_data;
        else if (state == ST_PULL_HI) pc_out[2*DATA_W-1:DATA_W] <= rd_data;
    end

    // Bank capture in native mode, cleared in emulation mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                bank_out <= '0;
        else if (state == ST_PULL_BANK)            bank_out <= rd_data;
        else if (state == ST_PULL_HI && !mode_q)   bank_out <= '0;
    end

    // Final pointer equals the address of the last pull.
    always_ff @(posedge clk) begin
        if (!rst_n)         sp_out <= '0;
        else if (last_pull) sp_out <= rd_addr;
    end

    // Emulation results carry both fixed status bits.
    p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !mode_q) |-> (flags_out[FLAG_BRK_POS] && flags_out[FLAG_FREE_POS]));
    // Emulation results carry a zero bank.
    p_bank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !mode_q) |-> (bank_out == '0));
    // Resume address high byte is the byte read in the previous cycle.
    p_pc_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PULL_HI) |-> (pc_out[2*DATA_W-1:DATA_W] == $past(rd_data)));

endmodule

// File: rtl/rti_unstacker.sv
// Module: rti_unstacker (top)
// Return-from-interrupt unstacker. It pulls status, resume address and, in
// native mode, the bank from a byte-wide stack and returns them with a done pulse.
// Assumes: combinational-read stack memory; a start is taken only when idle.
module rti_unstacker
    import rti_unstack_pkg::*;
#(
    parameter int                     SP_W       = 16,
    parameter int                     DATA_W     = 8,
    parameter logic [SP_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                native_mode,
    input  logic [SP_W-1:0]     sp_in,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [SP_W-1:0]     rd_addr,
    output logic                rd_en,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0]   bank_out,
    output logic [DATA_W-1:0]   flags_out,
    output logic [SP_W-1:0]     sp_out,
    output logic                done
);

    localparam int OFF_W = 3;

    rti_state_t       state;
    logic             mode_q;
    logic             accept;
    logic [OFF_W-1:0] offset;

    rti_seq #(.OFF_W(OFF_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .native_mode (native_mode),
        .state       (state),
        .mode_q      (mode_q),
        .accept      (accept),
        .rd_en       (rd_en),
        .done        (done),
        .offset      (offset)
    );

    rti_addr_gen #(
        .SP_W       (SP_W),
        .DATA_W     (DATA_W),
        .OFF_W      (OFF_W),
        .STACK_PAGE (STACK_PAGE)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .sp_in   (sp_in),
        .mode_q  (mode_q),
        .offset  (offset),
        .rd_addr (rd_addr)
    );

    rti_capture #(.SP_W(SP_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .mode_q    (mode_q),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .pc_out    (pc_out),
        .bank_out  (bank_out),
        .flags_out (flags_out),
        .sp_out    (sp_out)
    );

    // No read in the completion cycle.
    p_no_read_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);
    // Done follows a read cycle, never the gap or idle.
    p_done_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_en));

endmodule

// File: tb/rti_unstacker_bench.sv
`timescale 1ns/1ps
module rti_unstacker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        native_mode = 1'b0;
    logic [15:0] sp_in = '0;
    logic [7:0]  rd_data;
    logic [15:0] rd_addr;
    logic        rd_en;
    logic [15:0] pc_out;
    logic [7:0]  bank_out;
    logic [7:0]  flags_out;
    logic [15:0] sp_out;
    logic        done;
    logic [7:0]  seed = '0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a, input logic [7:0] s);
        return a[7:0] ^ 8'(a[15:8] * 8'd37) ^ s;
    endfunction

    assign rd_data = memf(rd_addr, seed);

    rti_unstacker u_rti_unstacker (
        .clk(clk), .rst_n(rst_n), .start(start), .native_mode(native_mode),
        .sp_in(sp_in), .rd_data(rd_data), .rd_addr(rd_addr), .rd_en(rd_en),
        .pc_out(pc_out), .bank_out(bank_out), .flags_out(flags_out),
        .sp_out(sp_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input bit nat, input logic [15:0] sp, input int k);
        if (nat) return sp + 16'(k);
        return {8'h01, 8'(sp[7:0] + 8'(k))};
    endfunction

    // One return operation with per-cycle checks; optionally a mid-run start.
    task automatic run_op(input bit nat, input logic [15:0] sp, input logic [7:0] s, input bit inject);
        int done_cyc = nat ? 6 : 5;
        int last_k   = nat ? 4 : 3;
        seed        = s;
        @(negedge clk);
        start       = 1'b1;
        native_mode = nat;
        sp_in       = sp;
        for (int cyc = 1; cyc <= 8; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && (cyc == 2 || cyc == 4)) begin
                start = 1'b1; native_mode = ~nat; sp_in = ~sp;   // R11 busy start
            end
            #1;
            begin
                bit exp_rd = (cyc >= 2) && (cyc <= 1 + last_k);
                chk(rd_en == exp_rd, nat ? "R4 strobe native" : "R4 strobe emul", 32'(rd_en), 32'(exp_rd));
                if (exp_rd)
                    chk(rd_addr == exp_addr(nat, sp, cyc - 1), nat ? "R6 addr" : "R5 addr",
                        32'(rd_addr), 32'(exp_addr(nat, sp, cyc - 1)));
                chk(done == (cyc == done_cyc), nat ? "R3 done timing" : "R2 done timing",
                    32'(done), 32'(cyc == done_cyc));
            end
            if (cyc == done_cyc) begin
                logic [7:0]  ef = memf(exp_addr(nat, sp, 1), s);
                logic [15:0] ep = {memf(exp_addr(nat, sp, 3), s), memf(exp_addr(nat, sp, 2), s)};
                logic [7:0]  eb = nat ? memf(exp_addr(nat, sp, 4), s) : 8'h00;
                if (!nat) ef = ef | 8'h30;
                chk(pc_out == ep, "R7 resume address", 32'(pc_out), 32'(ep));
                chk(flags_out == ef, nat ? "R9 flags" : "R8 flags", 32'(flags_out), 32'(ef));
                chk(bank_out == eb, nat ? "R9 bank" : "R8 bank", 32'(bank_out), 32'(eb));
                chk(sp_out == exp_addr(nat, sp, last_k), "R10 final pointer",
                    32'(sp_out), 32'(exp_addr(nat, sp, last_k)));
            end
            if (cyc == done_cyc + 1)
                chk(pc_out == {memf(exp_addr(nat, sp, 3), s), memf(exp_addr(nat, sp, 2), s)},
                    "R11 results held after pulse", 32'(pc_out), 32'(0));
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(done == 1'b0 && rd_en == 1'b0, "R1 reset strobes", {30'b0, done, rd_en}, 32'h0);
        chk(pc_out == 0 && bank_out == 0 && flags_out == 0 && sp_out == 0, "R1 reset values",
            {pc_out, flags_out, bank_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++)
            run_op(1'b0, {8'(i * 7), 8'(i)}, 8'(i * 13 + 5), (i % 16) == 3);
        for (int i = 0; i < 256; i++)
            run_op(1'b1, 16'hFF00 + 16'(i), 8'(i * 29 + 1), (i % 16) == 7);
        run_op(1'b1, 16'h0000, 8'hFF, 1'b0);
        run_op(1'b0, 16'hABFD, 8'h00, 1'b1);
        run_op(1'b1, 16'h01FE, 8'h5A, 1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule